// File: doc/BRIEF.md
# I2C Register-Access Slave

This block is the serial front end of a small register bank. It watches the two I2C lines as seen on a fast system clock. It recognises START, repeated START and STOP, and it compares the 7-bit address sent by the host with its own. On a match it gives the host byte-wide access to nine register locations, numbered 0 to 8, through an internal pointer. The register storage itself sits outside the block. The block drives a write port with a one-cycle strobe, plus a read address whose data must come back combinationally in the same cycle.

A write transaction sets the pointer with its first data byte. Each byte after that is stored at the pointer, and the pointer then advances. A read transaction shifts out bytes from the pointer position, most significant bit first, and advances the pointer after each byte is fetched. In both directions the pointer steps from location 8 back to location 0. A repeated START keeps the bus claimed and opens a new address phase, so the usual way to read is to write the pointer, issue a repeated START, and then read. SDA is open-drain: the block only ever pulls it low.

Top module: `i2cRegSlave`

## Requirements
- R1: After reset the block does not pull SDA low (sdaOutEn = 0), issues no write strobe, and its pointer, seen on regRdAddr, is 0.
- R2: The block acknowledges an address byte by pulling SDA low for the ninth clock only when the upper seven bits equal SLAVE_ADDR (default 7'h68). Bit 0 selects read (1) or write (0). The pull-down starts only while SCL is low.
- R3: After an address mismatch, SDA stays released and no register is written until the next START.
- R4: In a write transaction the first byte after the address loads the pointer and is acknowledged. A value above 8 loads 0.
- R5: Every later byte of a write transaction is acknowledged and produces exactly one single-cycle regWrEn pulse, carrying the pointer as address and the byte as data. The pointer then advances. SDA stays released while the host sends data bits.
- R6: In a write burst the pointer advances from 8 to 0.
- R7: In a read transaction the block sends the byte stored at the pointer, MSB first, and advances the pointer after each byte, stepping from 8 to 0. The pointer keeps its value between transactions.
- R8: When the host answers a read byte with NACK, the block stops driving SDA until the next START or STOP. Any further clocks read as all ones.
- R9: A repeated START, with no STOP before it, begins a fresh address phase. The pointer written before it is used by the read that follows.
- R10: After STOP the block is idle. Bit clocks that arrive without a new START are neither acknowledged nor written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level |
| sdaOutEn | output | 1 | 1 pulls SDA low, 0 releases it |
| regWrEn | output | 1 | One-cycle register write strobe |
| regWrAddr | output | 4 | Register write address |
| regWrData | output | 8 | Register write data |
| regRdAddr | output | 4 | Register read address (current pointer) |
| regRdData | input | 8 | Read data for regRdAddr, valid in the same cycle |

## Verification
Two events can land in the same system-clock cycle. On the eighth SCL rise of a write byte, the register write strobe and the pointer step happen together. On the ninth SCL fall of a read acknowledge, the next byte is fetched at the pointer and the pointer advances in the same cycle. The bench provokes both at the wrap point, with bursts that start at location 7 or 8. It judges the result by the contents of its own register model and by the exact bytes returned on a later read. Whether the host's NACK and the end of a byte are handled correctly is judged by reading a further byte and expecting all ones.

// File: rtl/i2cRegPkg.sv
package i2cRegPkg;

  typedef enum logic [2:0] {
    MODE_IDLE,
    MODE_ADDR,
    MODE_PTR,
    MODE_WR,
    MODE_RD,
    MODE_IGN
  } busMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;   // capture SDA into receive shifter
    logic loadPtr;   // completed byte becomes the pointer
    logic writeReg;  // completed byte goes to the register port
    logic loadTx;    // fetch byte at pointer, drive its MSB
    logic shiftTx;   // drive next transmit bit
    logic ackOn;     // pull SDA low for acknowledge
    logic relDrive;  // release SDA
  } dpStrobe_t;

endpackage

// File: rtl/i2cLineSync.sv
module i2cLineSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startCond,
  output logic stopCond
);
  logic [STAGES-1:0] sclSync, sdaSync;
  logic sclLvl, sclPrev, sdaPrev;

  generate
    if (STAGES == 1) begin : gOne
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclSync <= '1;
          sdaSync <= '1;
        end else begin
          sclSync <= sclIn;
          sdaSync <= sdaIn;
        end
      end
    end else begin : gChain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclSync <= '1;
          sdaSync <= '1;
        end else begin
          sclSync <= {sclSync[STAGES-2:0], sclIn};
          sdaSync <= {sdaSync[STAGES-2:0], sdaIn};
        end
      end
    end
  endgenerate

  assign sclLvl = sclSync[STAGES-1];
  assign sdaLvl = sdaSync[STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclLvl;
      sdaPrev <= sdaLvl;
    end
  end

  assign sclRise   = sclLvl & ~sclPrev;
  assign sclFall   = ~sclLvl & sclPrev;
  assign startCond = sclLvl & sclPrev & sdaPrev & ~sdaLvl;
  assign stopCond  = sclLvl & sclPrev & ~sdaPrev & sdaLvl;
endmodule

// File: rtl/i2cRegCtrl.sv
module i2cRegCtrl
  import i2cRegPkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h68
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startCond,
  input  logic       stopCond,
  input  logic       sdaLvl,
  input  logic [7:0] rxByteNow,
  output dpStrobe_t  strobe
);
  localparam logic [3:0] LAST_BIT = 4'd7;
  localparam logic [3:0] ACK_SLOT = 4'd8;
  localparam logic [3:0] BYTE_END = 4'd9;

  busMode_e   mode, nextMode;
  logic [3:0] bitCnt;
  logic       ackPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode     <= MODE_IDLE;
      nextMode <= MODE_IDLE;
      bitCnt   <= '0;
      ackPend  <= 1'b0;
    end else if (startCond) begin
      mode   <= MODE_ADDR;
      bitCnt <= '0;
    end else if (stopCond) begin
      mode   <= MODE_IDLE;
      bitCnt <= '0;
    end else if (sclRise && mode != MODE_IDLE) begin
      if (bitCnt < ACK_SLOT) begin
        bitCnt <= 4'(bitCnt + 4'd1);
        if (bitCnt == LAST_BIT) begin
          unique case (mode)
            MODE_ADDR: begin
              if (rxByteNow[7:1] == SLAVE_ADDR) begin
                ackPend  <= 1'b1;
                nextMode <= rxByteNow[0] ? MODE_RD : MODE_PTR;
              end else begin
                ackPend  <= 1'b0;
                nextMode <= MODE_IGN;
              end
            end
            MODE_PTR, MODE_WR: begin
              ackPend  <= 1'b1;
              nextMode <= MODE_WR;
            end
            MODE_RD: begin
              ackPend  <= 1'b0;
              nextMode <= MODE_RD;
            end
            default: begin
              ackPend  <= 1'b0;
              nextMode <= MODE_IGN;
            end
          endcase
        end
      end else if (bitCnt == ACK_SLOT) begin
        bitCnt <= BYTE_END;
        if (mode == MODE_RD) nextMode <= sdaLvl ? MODE_IGN : MODE_RD;
      end
    end else if (sclFall && mode != MODE_IDLE && bitCnt == BYTE_END) begin
      mode   <= nextMode;
      bitCnt <= '0;
    end
  end

  always_comb begin
    strobe = '0;
    if (startCond || stopCond) begin
      strobe.relDrive = 1'b1;
    end else if (sclRise && mode != MODE_IDLE) begin
      if (bitCnt < ACK_SLOT) begin
        strobe.shiftIn = (mode != MODE_RD);
        if (bitCnt == LAST_BIT) begin
          strobe.loadPtr  = (mode == MODE_PTR);
          strobe.writeReg = (mode == MODE_WR);
        end
      end
    end else if (sclFall && mode != MODE_IDLE) begin
      if (bitCnt == ACK_SLOT) begin
        strobe.ackOn    = ackPend;
        strobe.relDrive = ~ackPend;
      end else if (bitCnt == BYTE_END) begin
        strobe.loadTx   = (nextMode == MODE_RD);
        strobe.relDrive = (nextMode != MODE_RD);
      end else if (mode == MODE_RD && bitCnt != 4'd0) begin
        strobe.shiftTx = 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2cRegDatapath.sv
module i2cRegDatapath
  import i2cRegPkg::*;
#(
  parameter int NUM_REGS = 9,
  parameter int AW       = $clog2(NUM_REGS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     strobe,
  input  logic          sdaLvl,
  input  logic [7:0]    regRdData,
  output logic [7:0]    rxByteNow,
  output logic          sdaOutEn,
  output logic          regWrEn,
  output logic [AW-1:0] regWrAddr,
  output logic [7:0]    regWrData,
  output logic [AW-1:0] regRdAddr
);
  localparam logic [AW-1:0] LAST_IDX = AW'(NUM_REGS - 1);
  localparam logic [7:0]    LAST_8   = 8'(NUM_REGS - 1);

  logic [7:0]    rxShift, txShift;
  logic [AW-1:0] ptr;
  logic          driveLow;

  function automatic logic [AW-1:0] stepPtr(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : AW'(p + 1'b1);
  endfunction

  assign rxByteNow = {rxShift[6:0], sdaLvl};
  assign regRdAddr = ptr;
  assign sdaOutEn  = driveLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift   <= '0;
      txShift   <= '1;
      ptr       <= '0;
      driveLow  <= 1'b0;
      regWrEn   <= 1'b0;
      regWrAddr <= '0;
      regWrData <= '0;
    end else begin
      regWrEn <= 1'b0;
      if (strobe.shiftIn) rxShift <= rxByteNow;
      if (strobe.loadPtr) ptr <= (rxByteNow > LAST_8) ? '0 : AW'(rxByteNow);
      if (strobe.writeReg) begin
        regWrEn   <= 1'b1;
        regWrAddr <= ptr;
        regWrData <= rxByteNow;
        ptr       <= stepPtr(ptr);
      end
      if (strobe.loadTx) begin
        driveLow <= ~regRdData[7];
        txShift  <= {regRdData[6:0], 1'b1};
        ptr      <= stepPtr(ptr);
      end else if (strobe.shiftTx) begin
        driveLow <= ~txShift[7];
        txShift  <= {txShift[6:0], 1'b1};
      end else if (strobe.ackOn) begin
        driveLow <= 1'b1;
      end else if (strobe.relDrive) begin
        driveLow <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/i2cRegSlave.sv
module i2cRegSlave
  import i2cRegPkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR  = 7'h68,
  parameter int         NUM_REGS    = 9,
  parameter int         SYNC_STAGES = 2,
  localparam int        AW          = $clog2(NUM_REGS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sclIn,
  input  logic          sdaIn,
  output logic          sdaOutEn,
  output logic          regWrEn,
  output logic [AW-1:0] regWrAddr,
  output logic [7:0]    regWrData,
  output logic [AW-1:0] regRdAddr,
  input  logic [7:0]    regRdData
);
  logic       sdaLvl, sclRise, sclFall, startCond, stopCond;
  logic [7:0] rxByteNow;
  dpStrobe_t  strobe;

  i2cLineSync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startCond(startCond), .stopCond(stopCond)
  );

  i2cRegCtrl #(.SLAVE_ADDR(SLAVE_ADDR)) uCtrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startCond(startCond), .stopCond(stopCond), .sdaLvl(sdaLvl),
    .rxByteNow(rxByteNow), .strobe(strobe)
  );

  i2cRegDatapath #(.NUM_REGS(NUM_REGS), .AW(AW)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdaLvl(sdaLvl),
    .regRdData(regRdData), .rxByteNow(rxByteNow), .sdaOutEn(sdaOutEn),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .regRdAddr(regRdAddr)
  );
endmodule

// File: rtl/i2cRegSlaveChecker.sv
module i2cRegSlaveChecker #(
  parameter int NUM_REGS = 9,
  parameter int AW       = $clog2(NUM_REGS)
) (
  input logic          clk,
  input logic          rstN,
  input logic          sclIn,
  input logic          sdaOutEn,
  input logic          regWrEn,
  input logic [AW-1:0] regWrAddr,
  input logic [AW-1:0] regRdAddr
);
  localparam logic [AW-1:0] LAST_IDX = AW'(NUM_REGS - 1);

  assert_drive_on_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOutEn) |-> !sclIn);

  assert_wr_single_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);

  assert_release_on_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> !sdaOutEn);

  assert_wr_addr_range_R6: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> regWrAddr <= LAST_IDX);

  assert_rd_addr_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    regRdAddr <= LAST_IDX);
endmodule

bind i2cRegSlave i2cRegSlaveChecker #(.NUM_REGS(NUM_REGS)) uChecker (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOutEn(sdaOutEn),
  .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regRdAddr(regRdAddr)
);

// File: tb/i2cRegSlave_test.sv
module i2cRegSlave_test;
  localparam int Q = 10;
  localparam int H = 20;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclM = 1'b1;
  logic       mLow = 1'b0;
  logic       sdaLine;
  logic       sdaOutEn, regWrEn;
  logic [3:0] regWrAddr, regRdAddr;
  logic [7:0] regWrData, regRdData;
  logic [7:0] regs [9];
  int         wrCount = 0;
  int         nCmp = 0, nBad = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  assign sdaLine   = ~(mLow | sdaOutEn);
  assign regRdData = (regRdAddr < 4'd9) ? regs[regRdAddr] : 8'h00;

  i2cRegSlave uut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .sdaOutEn(sdaOutEn), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .regRdAddr(regRdAddr), .regRdData(regRdData)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 9; i++) regs[i] <= 8'h00;
    end else if (regWrEn) begin
      if (regWrAddr < 4'd9) regs[regWrAddr] <= regWrData;
      wrCount <= wrCount + 1;
    end
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic busStart();
    mLow = 1'b1; waitClk(H); sclM = 1'b0; waitClk(Q);
  endtask

  task automatic busRepStart();
    mLow = 1'b0; waitClk(Q); sclM = 1'b1; waitClk(H);
    mLow = 1'b1; waitClk(H); sclM = 1'b0; waitClk(Q);
  endtask

  task automatic busStop();
    mLow = 1'b1; waitClk(Q); sclM = 1'b1; waitClk(H);
    mLow = 1'b0; waitClk(H);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      mLow = ~b[i]; waitClk(Q); sclM = 1'b1; waitClk(H); sclM = 1'b0; waitClk(Q);
    end
    mLow = 1'b0; waitClk(Q); sclM = 1'b1; waitClk(H / 2);
    ack = ~sdaLine;
    waitClk(H / 2); sclM = 1'b0; waitClk(Q);
  endtask

  task automatic recvByte(input logic ackIt, output logic [7:0] b);
    mLow = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      waitClk(Q); sclM = 1'b1; waitClk(H / 2);
      b[i] = sdaLine;
      waitClk(H / 2); sclM = 1'b0;
    end
    waitClk(2); mLow = ackIt; waitClk(Q); sclM = 1'b1; waitClk(H);
    sclM = 1'b0; waitClk(2); mLow = 1'b0;
  endtask

  task automatic testReset();
    check("R1", "sdaOutEn", int'(sdaOutEn), 0);
    check("R1", "regWrEn", int'(regWrEn), 0);
    check("R1", "pointer", int'(regRdAddr), 0);
  endtask

  task automatic testWrite();
    logic a; int w0 = wrCount;
    busStart();
    sendByte(8'hD0, a); check("R2", "address ack", int'(a), 1);
    sendByte(8'h02, a); check("R4", "pointer ack", int'(a), 1);
    sendByte(8'hA1, a); check("R5", "data ack", int'(a), 1);
    sendByte(8'hB2, a); sendByte(8'hC3, a);
    busStop(); waitClk(4);
    check("R5", "write count", wrCount - w0, 3);
    check("R5", "reg2", int'(regs[2]), 'hA1);
    check("R5", "reg3", int'(regs[3]), 'hB2);
    check("R5", "reg4", int'(regs[4]), 'hC3);
  endtask

  task automatic testWriteWrap();
    logic a;
    busStart();
    sendByte(8'hD0, a); sendByte(8'h07, a);
    sendByte(8'h11, a); sendByte(8'h22, a); sendByte(8'h33, a);
    check("R6", "ack after wrap", int'(a), 1);
    busStop(); waitClk(4);
    check("R6", "reg7", int'(regs[7]), 'h11);
    check("R6", "reg8", int'(regs[8]), 'h22);
    check("R6", "reg0 after wrap", int'(regs[0]), 'h33);
  endtask

  task automatic testReadRepStartNack();
    logic a; logic [7:0] d;
    busStart();
    sendByte(8'hD0, a); sendByte(8'h02, a);
    busRepStart();
    sendByte(8'hD1, a); check("R9", "read address ack after Sr", int'(a), 1);
    recvByte(1'b1, d); check("R9", "first byte at pointer", int'(d), 'hA1);
    recvByte(1'b1, d); check("R7", "second byte", int'(d), 'hB2);
    recvByte(1'b0, d); check("R7", "third byte", int'(d), 'hC3);
    recvByte(1'b0, d); check("R8", "byte after NACK", int'(d), 'hFF);
    check("R8", "sda released after NACK", int'(sdaOutEn), 0);
    busStop();
  endtask

  task automatic testReadWrap();
    logic a; logic [7:0] d;
    busStart();
    sendByte(8'hD0, a); sendByte(8'h08, a);
    busRepStart();
    sendByte(8'hD1, a);
    recvByte(1'b1, d); check("R7", "byte at 8", int'(d), 'h22);
    recvByte(1'b0, d); check("R7", "byte after wrap", int'(d), 'h33);
    busStop();
  endtask

  task automatic testMismatch();
    logic a; int w0 = wrCount;
    busStart();
    sendByte(8'hA0, a); check("R2", "no ack on mismatch", int'(a), 0);
    sendByte(8'h00, a); check("R3", "no ack pointer", int'(a), 0);
    sendByte(8'h5A, a); check("R3", "no ack data", int'(a), 0);
    busStop(); waitClk(4);
    check("R3", "no writes", wrCount - w0, 0);
    check("R3", "reg0 kept", int'(regs[0]), 'h33);
  endtask

  task automatic testAfterStop();
    logic a; int w0 = wrCount;
    sclM = 1'b0; waitClk(Q);
    sendByte(8'hD0, a); check("R10", "no ack without START", int'(a), 0);
    sendByte(8'h00, a); sendByte(8'hEE, a);
    check("R10", "no ack data", int'(a), 0);
    busStop(); waitClk(4);
    check("R10", "no writes", wrCount - w0, 0);
  endtask

  task automatic testPtrRange();
    logic a; logic [7:0] d;
    busStart();
    sendByte(8'hD0, a); sendByte(8'h0C, a);
    check("R4", "ack out-of-range pointer", int'(a), 1);
    sendByte(8'h77, a); sendByte(8'h88, a);
    busStop(); waitClk(4);
    check("R4", "reg0 via clamped pointer", int'(regs[0]), 'h77);
    check("R4", "reg1", int'(regs[1]), 'h88);
    busStart();
    sendByte(8'hD1, a);
    recvByte(1'b0, d); check("R7", "pointer kept across transactions", int'(d), 'hA1);
    busStop();
  endtask

  initial begin
    waitClk(5);
    testReset();
    rstN = 1'b1;
    waitClk(5);
    testWrite();
    testWriteWrap();
    testReadRepStartNack();
    testReadWrap();
    testMismatch();
    testAfterStop();
    testPtrRange();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nCmp++;
      nBad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end
endmodule